// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block collects level-sensitive interrupt lines from on-chip units and one 4-bit encoded external level input. It chooses a single winner and presents it to the processor as a request flag with a fixed 12-bit vector code. On-chip lines are grouped: every line in a group reads its priority from one shared 4-bit field. The fields sit in 16-bit priority registers. Two lines, from an auxiliary timer pair, can also be blocked by a 32-bit mask register. That register has one write address that sets bits and another that clears them.

The processor supplies its current interrupt mask level. Only a winner whose priority is strictly above that level raises the request. Once raised, the request and vector stay frozen until the processor acknowledges. The controller then drops the request for one cycle and arbitrates again. Acceptance and nesting inside the processor are handled elsewhere.

Top module: `grp_intc`

## Requirements
- R1: After reset `irq_req` is 0 and `irq_vec` is 0. Every priority field is 0 and the mask register reads as all ones.
- R2: The priority register at write offset 0x00 holds the fields of lines 0 to 6: bits [15:12] for line 0, [11:8] for line 1, [7:4] for lines 2 and 3, and [3:0] for lines 4, 5 and 6. The register at offset 0x04 holds bits [15:12] for line 7, [11:8] for line 8, [3:0] for line 9, and [7:4] as a spare field with no line. Bits [31:16] of the write data are ignored.
- R3: All lines that share a field arbitrate at that field's value: lines 2 and 3, and lines 4, 5 and 6.
- R4: `src_pend` bit i is line i. Line i, from 0 to 9, presents these vectors in order: 0x400, 0x420, 0x440, 0x460, 0x480, 0x4A0, 0x4C0, 0x560, 0xB00, 0xB80. Every vector has its low five bits at zero.
- R5: A line whose priority field is 0 never requests.
- R6: A write to offset 0x40 sets every mask bit written as 1. A write to offset 0x60 clears every mask bit written as 1. Bits written as 0 keep their value. Mask bit 9 blocks line 8 and mask bit 8 blocks line 9; no other line is affected by the mask.
- R7: An external code n from 0 to 14 is a request at priority 15 − n with vector 0x200 + 0x20·n. Code 15 means no request. The mask register does not affect the external input, and it loses every tie to the on-chip lines.
- R8: The eligible request with the highest priority wins. On a tie, the lower line index wins.
- R9: A request is raised only if the winner's priority is strictly greater than `cpu_level`.
- R10: While `irq_req` is 1 and `ack` is 0, `irq_req` and `irq_vec` hold. With `ack` high at an edge, `irq_req` falls at that edge, and arbitration resumes at the next edge.
- R11: When the request is idle, a change on `src_pend`, `ext_code` or `cpu_level` shows at the outputs after one clock edge. A register write shows after two clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| src_pend | input | 10 | Level interrupt lines from on-chip units |
| ext_code | input | 4 | Encoded external level, 15 = idle |
| cpu_level | input | 4 | Processor's current interrupt mask level |
| ack | input | 1 | Processor acknowledge of the presented request |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | 12 | Vector code of the presented request |

## Verification
Line, level and threshold inputs feed a registered output stage through combinational arbitration, so a result is due one clock edge after the inputs change. Priority and mask writes pass through one more register, so their effect is due two edges after the write strobe. The bench drives every input on the falling edge. It waits for exactly the number of rising edges due and compares at the falling edge that follows, which includes the cycle in between where the request must still be low. The acknowledge sequence is likewise checked edge by edge: the hold while waiting, the drop on the acknowledge edge, and the new winner one edge later.

// File: rtl/grp_intc_pkg.sv
`timescale 1ns/1ps
package grp_intc_pkg;
  localparam int PRIO_W         = 4;
  localparam int FIELDS_PER_REG = 4;
  localparam int NUM_PRIO_REGS  = 2;
  localparam int NUM_FIELDS     = NUM_PRIO_REGS * FIELDS_PER_REG;
  localparam int PRIO_REG_W     = PRIO_W * FIELDS_PER_REG;
  localparam int NUM_SRC        = 10;
  localparam int VEC_W          = 12;
  localparam int MASK_W         = 32;
  localparam int EXT_W          = 4;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [VEC_W-1:0]  vec_t;

  // Global field index = register * FIELDS_PER_REG + slot; slot 3 is the top nibble.
  function automatic int src_field(input int s);
    case (s)
      0:       return 3;
      1:       return 2;
      2, 3:    return 1;
      4, 5, 6: return 0;
      7:       return 7;
      8:       return 6;
      9:       return 4;
      default: return 5;
    endcase
  endfunction

  function automatic vec_t src_vector(input int s);
    case (s)
      0:       return 12'h400;
      1:       return 12'h420;
      2:       return 12'h440;
      3:       return 12'h460;
      4:       return 12'h480;
      5:       return 12'h4A0;
      6:       return 12'h4C0;
      7:       return 12'h560;
      8:       return 12'hB00;
      9:       return 12'hB80;
      default: return 12'h000;
    endcase
  endfunction

  // Mask bit gating a line, -1 when the line is never masked.
  function automatic int src_mask_bit(input int s);
    case (s)
      8:       return 9;
      9:       return 8;
      default: return -1;
    endcase
  endfunction
endpackage

// File: rtl/grp_intc_regs.sv
`timescale 1ns/1ps
module grp_intc_regs
  import grp_intc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int PRIO_BASE   = 'h00,
  parameter int PRIO_STRIDE = 4,
  parameter int MASK_SET    = 'h40,
  parameter int MASK_CLR_OFS = 'h20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output prio_t                 fields [NUM_FIELDS],
  output logic [MASK_W-1:0]     mask
);
  localparam logic [ADDR_W-1:0] SET_ADDR = ADDR_W'(MASK_SET);
  localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(MASK_SET + MASK_CLR_OFS);

  logic [PRIO_REG_W-1:0] prio_q [NUM_PRIO_REGS];

  for (genvar r = 0; r < NUM_PRIO_REGS; r++) begin : g_prio
    localparam logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(PRIO_BASE + PRIO_STRIDE * r);
    always_ff @(posedge clk) begin
      if (rst)
        prio_q[r] <= '0;
      else if (wr_en && wr_addr == REG_ADDR)
        prio_q[r] <= wr_data[PRIO_REG_W-1:0];
    end
    for (genvar k = 0; k < FIELDS_PER_REG; k++) begin : g_field
      assign fields[r*FIELDS_PER_REG + k] = prio_q[r][k*PRIO_W +: PRIO_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      mask <= '1;
    else if (wr_en && wr_addr == SET_ADDR)
      mask <= mask | wr_data[MASK_W-1:0];
    else if (wr_en && wr_addr == CLR_ADDR)
      mask <= mask & ~wr_data[MASK_W-1:0];
  end
endmodule

// File: rtl/grp_intc_arb.sv
`timescale 1ns/1ps
module grp_intc_arb
  import grp_intc_pkg::*;
#(
  parameter int EXT_VEC_BASE = 'h200,
  parameter int EXT_STEP_SH  = 5
) (
  input  prio_t              fields [NUM_FIELDS],
  input  logic [MASK_W-1:0]  mask,
  input  logic [NUM_SRC-1:0] src_pend,
  input  logic [EXT_W-1:0]   ext_code,
  input  prio_t              cpu_level,
  output logic               win_valid,
  output vec_t               win_vec
);
  localparam int NUM_CAND = NUM_SRC + 1;
  localparam logic [EXT_W-1:0] EXT_IDLE = '1;

  logic  cand_elig [NUM_CAND];
  prio_t cand_prio [NUM_CAND];
  vec_t  cand_vec  [NUM_CAND];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam int FLD  = src_field(s);
    localparam int MBIT = src_mask_bit(s);
    logic blocked;
    if (MBIT >= 0) begin : g_masked
      assign blocked = mask[MBIT];
    end else begin : g_open
      assign blocked = 1'b0;
    end
    assign cand_prio[s] = fields[FLD];
    assign cand_vec[s]  = src_vector(s);
    assign cand_elig[s] = src_pend[s] && !blocked && (fields[FLD] != '0) &&
                          (fields[FLD] > cpu_level);
  end

  // External encoded level sits after all on-chip lines, so it loses ties.
  assign cand_prio[NUM_SRC] = (ext_code == EXT_IDLE) ? '0 : PRIO_W'(EXT_IDLE - ext_code);
  assign cand_vec[NUM_SRC]  = VEC_W'(EXT_VEC_BASE) + (VEC_W'(ext_code) << EXT_STEP_SH);
  assign cand_elig[NUM_SRC] = (ext_code != EXT_IDLE) && (cand_prio[NUM_SRC] > cpu_level);

  prio_t best_prio;
  always_comb begin
    win_valid = 1'b0;
    win_vec   = '0;
    best_prio = '0;
    // Scan downward with >= so the lowest index survives a tie.
    for (int s = NUM_CAND - 1; s >= 0; s--) begin
      if (cand_elig[s] && (!win_valid || cand_prio[s] >= best_prio)) begin
        win_valid = 1'b1;
        win_vec   = cand_vec[s];
        best_prio = cand_prio[s];
      end
    end
  end
endmodule

// File: rtl/grp_intc_out.sv
`timescale 1ns/1ps
module grp_intc_out
  import grp_intc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic win_valid,
  input  vec_t win_vec,
  input  logic ack,
  output logic irq_req,
  output vec_t irq_vec
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
    end else if (irq_req) begin
      if (ack) irq_req <= 1'b0;
    end else if (win_valid) begin
      irq_req <= 1'b1;
      irq_vec <= win_vec;
    end
  end
endmodule

// File: rtl/grp_intc.sv
`timescale 1ns/1ps
module grp_intc
  import grp_intc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [NUM_SRC-1:0] src_pend,
  input  logic [EXT_W-1:0]   ext_code,
  input  logic [PRIO_W-1:0]  cpu_level,
  input  logic               ack,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vec
);
  prio_t             fields [NUM_FIELDS];
  logic [MASK_W-1:0] mask;
  logic              win_valid;
  vec_t              win_vec;

  grp_intc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fields(fields), .mask(mask)
  );

  grp_intc_arb arb_i (
    .fields(fields), .mask(mask), .src_pend(src_pend), .ext_code(ext_code),
    .cpu_level(cpu_level), .win_valid(win_valid), .win_vec(win_vec)
  );

  grp_intc_out out_i (
    .clk(clk), .rst(rst), .win_valid(win_valid), .win_vec(win_vec), .ack(ack),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );
endmodule

// File: rtl/grp_intc_chk.sv
`timescale 1ns/1ps
module grp_intc_chk
  import grp_intc_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               ack,
  input logic [NUM_SRC-1:0] src_pend,
  input logic [EXT_W-1:0]   ext_code,
  input logic               irq_req,
  input logic [VEC_W-1:0]   irq_vec
);
  assert_vec_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !ack) |=> (irq_req && $stable(irq_vec)));

  assert_ack_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (irq_req && ack) |=> !irq_req);

  assert_no_source_R9: assert property (@(posedge clk) disable iff (rst)
    (!irq_req && src_pend == '0 && ext_code == '1) |=> !irq_req);

  assert_vec_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec[4:0] == 5'd0));

  assert_ext_range_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_req && irq_vec < 12'h400) |-> (irq_vec >= 12'h200 && irq_vec <= 12'h3C0));
endmodule

bind grp_intc grp_intc_chk chk_i (
  .clk(clk), .rst(rst), .ack(ack), .src_pend(src_pend), .ext_code(ext_code),
  .irq_req(irq_req), .irq_vec(irq_vec)
);

// File: tb/grp_intc_tb.sv
`timescale 1ns/1ps
module grp_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [9:0]  src_pend = '0;
  logic [3:0]  ext_code = 4'hF;
  logic [3:0]  cpu_level = '0;
  logic        ack = 1'b0;
  logic        irq_req;
  logic [11:0] irq_vec;

  int n_checks = 0;
  int n_errs = 0;
  logic [15:0] sh_r0 = '0, sh_r1 = '0;
  logic [31:0] sh_mask = '1;

  always #5 clk = ~clk;

  grp_intc dut_i (.*);

  task automatic check(input logic ok, input string tag, input int act, input int exp_v);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp_v);
    end
  endtask

  function automatic int fld(input int s);
    case (s)
      0: return int'(sh_r0[15:12]);
      1: return int'(sh_r0[11:8]);
      2, 3: return int'(sh_r0[7:4]);
      4, 5, 6: return int'(sh_r0[3:0]);
      7: return int'(sh_r1[15:12]);
      8: return int'(sh_r1[11:8]);
      default: return int'(sh_r1[3:0]);
    endcase
  endfunction

  function automatic int vtab(input int s);
    case (s)
      0: return 'h400; 1: return 'h420; 2: return 'h440; 3: return 'h460;
      4: return 'h480; 5: return 'h4A0; 6: return 'h4C0; 7: return 'h560;
      8: return 'hB00; default: return 'hB80;
    endcase
  endfunction

  function automatic void model(input logic [9:0] pend, input int ext, input int lvl,
                                output logic v, output int vec);
    int bp = 0;
    v = 1'b0; vec = 0;
    for (int s = 0; s < 10; s++) begin
      int p = fld(s);
      logic blk = (s == 8) ? sh_mask[9] : (s == 9) ? sh_mask[8] : 1'b0;
      if (pend[s] && !blk && p > lvl && p > bp) begin bp = p; v = 1'b1; vec = vtab(s); end
    end
    if (ext != 15) begin
      int p = 15 - ext;
      if (p > lvl && p > bp) begin v = 1'b1; vec = 'h200 + 32 * ext; end
    end
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 8'h00) sh_r0 = d[15:0];
    if (a == 8'h04) sh_r1 = d[15:0];
    if (a == 8'h40) sh_mask = sh_mask | d;
    if (a == 8'h60) sh_mask = sh_mask & ~d;
    @(negedge clk);
  endtask

  task automatic release_all();
    ack = 1'b1; src_pend = '0; ext_code = 4'hF;
    @(negedge clk);
    ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic scen(input logic [9:0] pend, input int ext, input int lvl, input string tag);
    logic v; int vec;
    model(pend, ext, lvl, v, vec);
    src_pend = pend; ext_code = 4'(ext); cpu_level = 4'(lvl);
    @(negedge clk);
    check(irq_req == v, tag, int'(irq_req), int'(v));
    if (v) check(int'(irq_vec) == vec, tag, int'(irq_vec), vec);
    release_all();
  endtask

  initial begin
    #1_000_000;
    n_errs++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

  initial begin
    logic [15:0] r0s [4] = '{16'h8765, 16'h5555, 16'h0F0F, 16'h1111};
    logic [15:0] r1s [4] = '{16'h4321, 16'h5555, 16'hF0F0, 16'h0000};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(irq_req == 1'b0, "R1 req after reset", int'(irq_req), 0);
    check(irq_vec == '0, "R1 vec after reset", int'(irq_vec), 0);
    // R1/R5: zero fields keep everything quiet
    scen(10'h3FF, 15, 0, "R1 R5 zero fields");
    // R6: reset mask blocks line 8 even with a nonzero field
    wr(8'h04, 32'h0A00);
    scen(10'h100, 15, 0, "R6 reset mask blocks line 8");
    wr(8'h60, 32'hFFFF_FFFF);

    // R2 R3 R4 R5 R8 R9: exhaustive line patterns over several field settings
    for (int c = 0; c < 4; c++) begin
      wr(8'h00, {16'hDEAD, r0s[c]});
      wr(8'h04, {16'hBEEF, r1s[c]});
      for (int p = 0; p < 1024; p++)
        scen(10'(p), 15, p % 8, "R2 R3 R4 R5 R8 R9 sweep");
    end

    // R7: every external code, alone and against line 0 at priority 8
    wr(8'h00, 32'h8000);
    wr(8'h04, 32'h0000);
    for (int e = 0; e < 16; e++) begin
      scen(10'h000, e, 0, "R7 ext alone");
      scen(10'h001, e, 0, "R7 ext vs line0 tie");
      scen(10'h000, e, 6, "R7 R9 ext vs level");
    end

    // R6: set and clear addresses
    wr(8'h04, 32'h0A0B);
    wr(8'h40, 32'h0000_0200);
    scen(10'h100, 15, 0, "R6 bit9 blocks line 8");
    scen(10'h200, 15, 0, "R6 line 9 unaffected");
    scen(10'h300, 15, 0, "R6 mixed");
    wr(8'h60, 32'h0000_0000);
    scen(10'h100, 15, 0, "R6 clear of zeros no effect");
    wr(8'h40, 32'h0000_0001);
    scen(10'h001, 15, 0, "R6 bit0 does not gate line 0");
    wr(8'h40, 32'h0000_0100);
    scen(10'h300, 15, 0, "R6 both blocked");
    wr(8'h60, 32'h0000_0200);
    scen(10'h300, 15, 0, "R6 line 8 released");

    // R10: hold while pending ack, then re-arbitrate
    wr(8'h00, 32'h3900);
    src_pend = 10'h001; cpu_level = 4'd0;
    @(negedge clk);
    check(irq_req && irq_vec == 12'h400, "R10 first grant", int'(irq_vec), 'h400);
    src_pend = 10'h003;
    repeat (3) @(negedge clk);
    check(irq_req && irq_vec == 12'h400, "R10 held while waiting", int'(irq_vec), 'h400);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    check(irq_req == 1'b0, "R10 drop on ack", int'(irq_req), 0);
    @(negedge clk);
    check(irq_req && irq_vec == 12'h420, "R10 re-arbitrated", int'(irq_vec), 'h420);
    release_all();

    // R11: write latency of two edges
    wr(8'h00, 32'h0000);
    src_pend = 10'h001;
    @(negedge clk);
    check(irq_req == 1'b0, "R11 disabled before write", int'(irq_req), 0);
    wr_en = 1'b1; wr_addr = 8'h00; wr_data = 32'h5000;
    @(negedge clk);
    wr_en = 1'b0;
    check(irq_req == 1'b0, "R11 one edge after write", int'(irq_req), 0);
    @(negedge clk);
    check(irq_req && irq_vec == 12'h400, "R11 two edges after write", int'(irq_vec), 'h400);
    release_all();

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end
endmodule